// File: doc/BRIEF.md
# Write-Completion Status Poller

This block runs on the host side of a parallel flash interface. Once a program or erase command sequence has been issued to the flash, the poller decides when the device has finished its internal operation. It is started with the target word address, the data word being written (all ones for an erase) and a detection method. It then issues a series of read requests for that address and judges each returned word. Some other agent performs the reads on the physical bus.

Two detection methods are offered. In data-compare mode, a write in progress returns the inverse of the written bit 7, so a returned word equal to the expected word suggests that the write is complete. In toggle mode, bit 6 flips on every read while the device is busy, so two reads in a row with the same bit 6 suggest that the write is complete. The end of the write is asynchronous to the host, so a single read can mislead. Every apparent completion is therefore confirmed by two more reads of the same location. If either of those reads fails, polling resumes. A poll budget bounds the whole exchange, and the poller reports the result with a one-cycle done pulse or a one-cycle timeout pulse.

Reads leave the block on a valid/ready request channel and return on a valid/ready response channel, with at most one read outstanding. A request is held, with its address stable, until the consumer raises `rd_req_ready`; the consumer may stall it for any number of cycles. The poller raises `rd_rsp_ready` only while it waits for the reply, and a response offered at any other time is not taken.

Top module: `wc_poller`

## Requirements
- R1: While and directly after reset, `busy`, `rd_req_valid`, `rd_rsp_ready`, `done` and `timeout` are all low.
- R2: The poller accepts `start` only while `busy` is low. A `start` raised while busy changes neither the request address, the mode, the expected word, the budget nor the outcome of the poll in progress. After an accepted start, `busy` is high in the next cycle.
- R3: Every request carries the start address. A request whose `rd_req_ready` is low stays valid with the same address in the next cycle.
- R4: In data-compare mode (`start_mode` = 0), a response counts as a completed read only when all `DATA_W` bits equal the expected word.
- R5: In toggle mode (`start_mode` = 1), a response counts as a completed read only when its bit 6 equals bit 6 of the previous response in the same poll. The first response of a poll never counts.
- R6: After the first completed read, the poller issues two more reads and declares done only if both of them count as completed. A failed confirmation read returns the poller to normal polling, and the next completed read starts a fresh pair of confirmations.
- R7: In toggle mode, each confirmation read is compared with the response directly before it, so the bit 6 change that breaks a confirmation also becomes the reference for the next read.
- R8: When the number of responses in a poll reaches the budget `max_polls` (0 is treated as 1) without done, the poller raises `timeout`. When the last allowed response completes the confirmation, done is reported and timeout is not.
- R9: `done` and `timeout` are single-cycle pulses that never occur together. Each rises in the cycle after the response handshake that decided it, and `busy` is low in that same cycle.
- R10: `rd_req_valid` and `rd_rsp_ready` are never high together, and both are low while idle. Only one read is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a poll; taken only while idle |
| start_addr | input | ADDR_W | Word address of the written location |
| start_data | input | DATA_W | Word that was written (all ones after an erase) |
| start_mode | input | 1 | 0 = data-compare, 1 = toggle-bit |
| max_polls | input | CNT_W | Response budget for the poll; 0 acts as 1 |
| busy | output | 1 | A poll is in progress |
| rd_req_valid | output | 1 | Read request offered |
| rd_req_ready | input | 1 | Consumer takes the read request |
| rd_req_addr | output | ADDR_W | Address of the read request |
| rd_rsp_valid | input | 1 | Read data offered |
| rd_rsp_ready | output | 1 | Poller waits for read data |
| rd_rsp_data | input | DATA_W | Returned status or data word |
| done | output | 1 | One-cycle pulse: write confirmed complete |
| timeout | output | 1 | One-cycle pulse: budget used up |

## Verification
All outputs come from registers, so each response has a fixed delay:
- `rd_req_valid` rises in the cycle after an accepted start.
- `rd_rsp_ready` rises in the cycle after the request handshake.
- `done` or `timeout` rises in the cycle after the response handshake that decided it.

The bench acts one time unit after each rising edge. It reads the outputs produced by that edge and sets the inputs for the next edge, so every handshake it arranges lands on the following edge. Each poll runs against a scripted sequence of response words, with random stalls on both channels. The bench compares the number of responses consumed and the kind of pulse against a reference walk through the same script. It also checks one cycle after the pulse that the pulse has dropped.

// File: rtl/wcp_pkg.sv
package wcp_pkg;
  typedef enum logic [1:0] {
    PS_IDLE  = 2'd0,
    PS_ISSUE = 2'd1,
    PS_AWAIT = 2'd2
  } poll_state_t;

  typedef enum logic {
    MODE_DATA   = 1'b0,
    MODE_TOGGLE = 1'b1
  } poll_mode_t;

  // confirmation reads still required after an apparent completion
  localparam int unsigned CONFIRM_READS = 2;
endpackage

// File: rtl/wcp_judge.sv
// Decides whether one returned word looks like a finished write.
module wcp_judge
  import wcp_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned TOG_BIT = 6
) (
  input  poll_mode_t        mode,
  input  logic [DATA_W-1:0] expect_word,
  input  logic [DATA_W-1:0] rd_word,
  input  logic              prev_bit,
  input  logic              have_prev,
  output logic              settled
);
  logic data_match;
  logic tog_steady;

  assign data_match = (rd_word == expect_word);
  assign tog_steady = have_prev && (rd_word[TOG_BIT] == prev_bit);

  always_comb begin
    unique case (mode)
      MODE_DATA:   settled = data_match;
      MODE_TOGGLE: settled = tog_steady;
      default:     settled = 1'b0;
    endcase
  end
endmodule

// File: rtl/wcp_poll_counter.sv
// Counts responses of one poll and flags the last one allowed.
module wcp_poll_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             bump,
  input  logic [CNT_W-1:0] limit,
  output logic             last
);
  localparam int unsigned EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [EXT_W-1:0] cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + EXT_W'(1);
  assign last    = (cnt_inc >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cnt_q <= '0;
    end else if (bump && !cnt_inc[CNT_W]) begin
      cnt_q <= cnt_inc[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/wc_poller.sv
module wc_poller
  import wcp_pkg::*;
#(
  parameter int unsigned ADDR_W  = 21,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned TOG_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [DATA_W-1:0] start_data,
  input  logic              start_mode,
  input  logic [CNT_W-1:0]  max_polls,
  output logic              busy,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [DATA_W-1:0] rd_rsp_data,
  output logic              done,
  output logic              timeout
);
  localparam int unsigned CONF_W = $clog2(CONFIRM_READS + 1);

  poll_state_t       state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] exp_q;
  poll_mode_t        mode_q;
  logic [CNT_W-1:0]  lim_q;
  logic              prev_q, have_prev_q;
  logic [CONF_W-1:0] conf_q, conf_d;
  logic              done_q, to_q;

  logic accept, req_fire, rsp_fire, settled, at_last;
  logic finish_ok, finish_to;

  assign accept   = start && (state_q == PS_IDLE);
  assign req_fire = (state_q == PS_ISSUE) && rd_req_ready;
  assign rsp_fire = (state_q == PS_AWAIT) && rd_rsp_valid;

  wcp_judge #(
    .DATA_W (DATA_W),
    .TOG_BIT(TOG_BIT)
  ) u_judge (
    .mode       (mode_q),
    .expect_word(exp_q),
    .rd_word    (rd_rsp_data),
    .prev_bit   (prev_q),
    .have_prev  (have_prev_q),
    .settled    (settled)
  );

  wcp_poll_counter #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(accept),
    .bump (rsp_fire),
    .limit(lim_q),
    .last (at_last)
  );

  // confirmation tracking: 0 = plain polling, otherwise reads still owed
  always_comb begin
    conf_d = conf_q;
    if (conf_q != '0) begin
      conf_d = settled ? conf_q - CONF_W'(1) : '0;
    end else if (settled) begin
      conf_d = CONF_W'(CONFIRM_READS);
    end
  end

  assign finish_ok = rsp_fire && (conf_q == CONF_W'(1)) && settled;
  assign finish_to = rsp_fire && !finish_ok && at_last;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_IDLE:  if (accept) state_d = PS_ISSUE;
      PS_ISSUE: if (req_fire) state_d = PS_AWAIT;
      PS_AWAIT: if (rsp_fire) state_d = (finish_ok || finish_to) ? PS_IDLE : PS_ISSUE;
      default:  state_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= PS_IDLE;
      addr_q      <= '0;
      exp_q       <= '0;
      mode_q      <= MODE_DATA;
      lim_q       <= CNT_W'(1);
      prev_q      <= 1'b0;
      have_prev_q <= 1'b0;
      conf_q      <= '0;
      done_q      <= 1'b0;
      to_q        <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= finish_ok;
      to_q    <= finish_to;
      if (accept) begin
        addr_q      <= start_addr;
        exp_q       <= start_data;
        mode_q      <= poll_mode_t'(start_mode);
        lim_q       <= (max_polls == '0) ? CNT_W'(1) : max_polls;
        prev_q      <= 1'b0;
        have_prev_q <= 1'b0;
        conf_q      <= '0;
      end else if (rsp_fire) begin
        prev_q      <= rd_rsp_data[TOG_BIT];
        have_prev_q <= 1'b1;
        conf_q      <= conf_d;
      end
    end
  end

  assign busy         = (state_q != PS_IDLE);
  assign rd_req_valid = (state_q == PS_ISSUE);
  assign rd_rsp_ready = (state_q == PS_AWAIT);
  assign rd_req_addr  = addr_q;
  assign done         = done_q;
  assign timeout      = to_q;
endmodule

// File: rtl/wcp_checker.sv
module wcp_checker #(
  parameter int unsigned ADDR_W = 21
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_req_addr,
  input logic              rd_rsp_valid,
  input logic              rd_rsp_ready,
  input logic              done,
  input logic              timeout
);
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout)); // R9
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done || timeout) |=> !(done || timeout)); // R9
  AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done || timeout) |-> !busy); // R9
  AST_END_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (done || timeout) |-> $past(rd_rsp_valid && rd_rsp_ready)); // R9
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr))); // R3
  AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_valid && rd_rsp_ready)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rd_req_valid && !rd_rsp_ready)); // R10
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R2
  AST_ADDR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(rd_req_addr)); // R2
endmodule

bind wc_poller wcp_checker #(
  .ADDR_W(ADDR_W)
) u_wcp_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .busy        (busy),
  .rd_req_valid(rd_req_valid),
  .rd_req_ready(rd_req_ready),
  .rd_req_addr (rd_req_addr),
  .rd_rsp_valid(rd_rsp_valid),
  .rd_rsp_ready(rd_rsp_ready),
  .done        (done),
  .timeout     (timeout)
);

// File: tb/tb_wc_poller.sv
module tb_wc_poller;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 21;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 16;
  localparam int SCR_N  = 64;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] start_addr = '0;
  logic [DATA_W-1:0] start_data = '0;
  logic              start_mode = 1'b0;
  logic [CNT_W-1:0]  max_polls = '0;
  logic              busy, rd_req_valid, rd_rsp_ready, done, timeout;
  logic              rd_req_ready = 1'b0;
  logic              rd_rsp_valid = 1'b0;
  logic [ADDR_W-1:0] rd_req_addr;
  logic [DATA_W-1:0] rd_rsp_data = '0;

  int checks = 0;
  int fails  = 0;
  logic [DATA_W-1:0] scr [SCR_N];

  always #(CLK_PERIOD/2) clk = ~clk;

  wc_poller #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .start_data(start_data), .start_mode(start_mode), .max_polls(max_polls),
    .busy(busy), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid),
    .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data),
    .done(done), .timeout(timeout)
  );

  task automatic chk(input string req, input bit ok, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  // Reference walk over the script: kind 1 = done, 2 = timeout, 0 = undecided
  task automatic ref_run(input bit mode, input logic [DATA_W-1:0] expw,
                         input int maxp, output int kind, output int n);
    bit have_prev = 0;
    bit prev = 0;
    int conf = 0;
    bit ok;
    int lim = (maxp == 0) ? 1 : maxp;
    kind = 0;
    n = 0;
    for (int i = 0; i < SCR_N; i++) begin
      ok = (mode == 1'b0) ? (scr[i] == expw) : (have_prev && scr[i][6] == prev);
      if (conf > 0) begin
        conf = ok ? conf - 1 : 0;
        if (ok && conf == 0) begin
          kind = 1; n = i + 1; return;
        end
      end else if (ok) begin
        conf = 2;
      end
      have_prev = 1;
      prev = scr[i][6];
      if (i + 1 >= lim) begin
        kind = 2; n = i + 1; return;
      end
    end
  endtask

  task automatic run_case(input string tag, input bit mode, input logic [DATA_W-1:0] expw,
                          input int maxp, input bit poke);
    int ekind, en, idx, cyc, got;
    bit bad_addr, overlap, both;
    logic [ADDR_W-1:0] addr;
    ref_run(mode, expw, maxp, ekind, en);
    addr = ADDR_W'($urandom);
    @(posedge clk); #1;
    start = 1'b1; start_addr = addr; start_data = expw;
    start_mode = mode; max_polls = CNT_W'(maxp);
    idx = 0; cyc = 0; got = 0; bad_addr = 0; overlap = 0; both = 0;
    while (cyc < 4000) begin
      @(posedge clk); #1;
      cyc++;
      if (done && timeout) both = 1;
      if (done) got = 1;
      else if (timeout) got = 2;
      if (got != 0) break;
      if (rd_req_valid && rd_rsp_ready) overlap = 1;
      if (poke && cyc == 3) begin
        // R2: a start while busy must be ignored
        start = 1'b1; start_addr = ~addr; start_mode = ~mode;
        start_data = ~expw; max_polls = CNT_W'(1);
      end else begin
        start = 1'b0;
      end
      rd_req_ready = ($urandom % 3) != 0;
      if (rd_req_valid && rd_req_ready && rd_req_addr != addr) bad_addr = 1;
      if (rd_rsp_ready && ($urandom % 3) != 0) begin
        rd_rsp_valid = 1'b1;
        rd_rsp_data = (idx < SCR_N) ? scr[idx] : '0;
        idx++;
      end else begin
        rd_rsp_valid = 1'b0;
        rd_rsp_data = DATA_W'($urandom);
      end
    end
    start = 1'b0; rd_req_ready = 1'b0; rd_rsp_valid = 1'b0;
    chk("R8", got == ekind && !both,
        $sformatf("%s outcome actual %0d expected %0d", tag, got, ekind));
    chk("R6", idx == en, $sformatf("%s responses used actual %0d expected %0d", tag, idx, en));
    chk("R3", !bad_addr, $sformatf("%s request address mismatch actual 1 expected 0", tag));
    chk("R10", !overlap, $sformatf("%s request and response overlap actual 1 expected 0", tag));
    chk("R9", !busy, $sformatf("%s busy at pulse actual %0b expected 0", tag, busy));
    @(posedge clk); #1;
    chk("R9", !done && !timeout,
        $sformatf("%s pulse width actual %0b%0b expected 00", tag, done, timeout));
  endtask

  task automatic gen(input bit mode, input logic [DATA_W-1:0] expw);
    int inprog = 2 + int'($urandom % 10);
    bit b0 = 1'($urandom);
    logic [DATA_W-1:0] w;
    for (int i = 0; i < SCR_N; i++) begin
      w = DATA_W'($urandom);
      if (mode == 1'b0) begin
        if (i < inprog) begin
          w[7] = ~expw[7];
          if ($urandom % 6 == 0) w = expw;
        end else begin
          w = expw;
        end
      end else begin
        if (i < inprog) begin
          w[6] = b0 ^ i[0];
          if ($urandom % 6 == 0 && i > 0) w[6] = scr[i-1][6];
        end else begin
          w[6] = (i > 0) ? scr[i-1][6] : b0;
        end
      end
      scr[i] = w;
    end
  endtask

  task automatic fill_toggle(input logic [31:0] bits, input int len);
    for (int i = 0; i < SCR_N; i++) begin
      scr[i] = DATA_W'($urandom);
      scr[i][6] = (i < len) ? bits[i] : bits[len-1];
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run hung actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] e;
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(posedge clk);
    #1;
    chk("R1", !busy && !rd_req_valid && !rd_rsp_ready && !done && !timeout,
        $sformatf("reset outputs actual %0b%0b%0b%0b%0b expected 00000",
                  busy, rd_req_valid, rd_rsp_ready, done, timeout));
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1", !busy && !done && !timeout, "after reset actual active expected idle");

    // R4: data-compare, clean finish after four busy reads
    e = 16'h3C5A;
    for (int i = 0; i < SCR_N; i++) scr[i] = (i < 4) ? (e ^ 16'h0080) : e;
    run_case("R4 data clean", 1'b0, e, 50, 1'b0);
    // R6: confirmation broken by a busy read, then fresh confirmation
    for (int i = 0; i < SCR_N; i++) scr[i] = e;
    scr[0] = e ^ 16'h0080; scr[2] = e ^ 16'h0081; scr[3] = e ^ 16'h0080;
    run_case("R6 data glitch", 1'b0, e, 50, 1'b0);
    // R5 R7: toggle 0,1,0,1,1,1,1
    fill_toggle(32'b1111010, 7);
    run_case("R5 toggle clean", 1'b1, e, 50, 1'b0);
    // R7: toggle 0,1,1,0,1,0,0,0,0 breaks then re-confirms
    fill_toggle(32'b000010110, 9);
    run_case("R7 toggle glitch", 1'b1, e, 50, 1'b0);
    // R5: steady bit 6 from the first read, first read never counts
    fill_toggle(32'b0, 1);
    run_case("R5 first read", 1'b1, e, 50, 1'b0);
    // R8: budget of 4 while still toggling
    fill_toggle(32'h5555_5555, 32);
    run_case("R8 timeout", 1'b1, e, 4, 1'b0);
    run_case("R8 zero budget", 1'b1, e, 0, 1'b0);
    // R8: completion on the last allowed response
    for (int i = 0; i < SCR_N; i++) scr[i] = e;
    run_case("R8 done at limit", 1'b0, e, 3, 1'b0);
    // R2: start while busy is ignored
    for (int i = 0; i < SCR_N; i++) scr[i] = (i < 6) ? (e ^ 16'h0080) : e;
    run_case("R2 start while busy", 1'b0, e, 50, 1'b1);

    for (int k = 0; k < 24; k++) begin
      bit m = 1'($urandom);
      e = DATA_W'($urandom);
      gen(m, e);
      run_case($sformatf("random %0d", k), m, e, 1 + int'($urandom % 40), (k % 5) == 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule